// File: doc/BRIEF.md
# Programmable Baud Rate Divider

This block divides a single reference clock by a programmable 16-bit value and emits a one-cycle enable pulse. The pulse rate is sixteen times the serial bit rate of the UART it serves. The divisor is written one byte at a time, into a low-byte register and a high-byte register. Each register has its own write strobe, and both share one 8-bit data bus. The full 16-bit divisor is always visible on a readback port.

A down-counter produces the pulse. It is loaded with the divisor, steps down once per reference cycle, raises the tick in the cycle it holds 1, and then reloads. Any write to either byte register reloads the counter at once with the newly written divisor. A retuned rate therefore takes effect within one divisor period, and a long leftover count from the old setting cannot delay it. A divisor of zero is treated as divide-by-3, so the counter never stalls.

Top module: `baud_gen`

## Requirements
- R1: After reset, `divisor_o` reads 0 and the tick is low while reset is held. The tick is first high in the second cycle after reset is released, and then repeats every 3 cycles.
- R2: A write with `wr_lo_i` high stores `wdata_i` into `divisor_o[7:0]` at that clock edge and leaves `divisor_o[15:8]` unchanged.
- R3: A write with `wr_hi_i` high stores `wdata_i` into `divisor_o[15:8]` at that clock edge and leaves `divisor_o[7:0]` unchanged.
- R4: With a divisor N from 2 to 65535 and no writes, `tick_o` is high for exactly one cycle out of every N.
- R5: With a divisor of 1, `tick_o` is high in every cycle.
- R6: With a divisor of 0, `tick_o` is high for one cycle out of every 3.
- R7: A write to either byte reloads the counter at that clock edge. If the resulting effective divisor is N, the tick is first high in the N-th cycle after the write edge, counting the cycle right after that edge as cycle 1.
- R8: If both strobes are high in the same cycle, both bytes take the value of `wdata_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_lo_i | input | 1 | Write strobe for the divisor low byte |
| wr_hi_i | input | 1 | Write strobe for the divisor high byte |
| wdata_i | input | 8 | Write data for either byte |
| divisor_o | output | 16 | Current divisor, high byte over low byte |
| tick_o | output | 1 | One-cycle enable pulse at 16x the baud rate |

## Verification
The main function is driven with a table of divisors: 0, 1 and 2, a small odd value, and values whose high byte alone or both bytes are non-zero. These values separate the divide-by-3 substitution, the always-high case, the narrowest true pulse, and carries between the two bytes of the counter. For each divisor, the bench measures the delay from the write to the first tick, which shows the reload. It also measures the spacing between ticks and the pulse width. Directed tests then cover the count after reset, a reload in the middle of a long count, byte-isolated writes, and a write with both strobes high.

// File: rtl/baud_pkg.sv
package baud_pkg;
  localparam int unsigned DIV_W    = 16;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned ZERO_DIV = 3;  // substitute for a zero divisor
endpackage

// File: rtl/baud_div_latch.sv
module baud_div_latch #(
  parameter int unsigned BYTE_W    = baud_pkg::BYTE_W,
  parameter int unsigned NUM_BYTES = 2,
  localparam int unsigned DIV_W    = BYTE_W * NUM_BYTES
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_BYTES-1:0] wr_en_i,
  input  logic [BYTE_W-1:0]    wdata_i,
  output logic [DIV_W-1:0]     div_q_o,
  output logic [DIV_W-1:0]     div_d_o
);
  logic [DIV_W-1:0] div_q;

  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign div_d_o[b*BYTE_W +: BYTE_W] = wr_en_i[b] ? wdata_i : div_q[b*BYTE_W +: BYTE_W];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) div_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en_i[b]) div_q[b*BYTE_W +: BYTE_W] <= wdata_i;
    end
  end

  assign div_q_o = div_q;
endmodule

// File: rtl/baud_div_counter.sv
module baud_div_counter #(
  parameter int unsigned DIV_W    = baud_pkg::DIV_W,
  parameter int unsigned ZERO_DIV = baud_pkg::ZERO_DIV
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] div_i,   // divisor in force after this edge
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ZERO_SUB = DIV_W'(ZERO_DIV);
  localparam logic [DIV_W-1:0] ONE      = DIV_W'(1);

  logic [DIV_W-1:0] cnt_q, cnt_d, eff_div;
  logic             at_one;

  assign eff_div = (div_i == '0) ? ZERO_SUB : div_i;
  assign at_one  = (cnt_q == ONE);

  always_comb begin
    if (load_i || at_one) cnt_d = eff_div;
    else                  cnt_d = cnt_q - ONE;
  end

  // reset divisor is zero, so the counter starts at the substitute value
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= ZERO_SUB;
    else         cnt_q <= cnt_d;
  end

  assign tick_o = at_one;
endmodule

// File: rtl/baud_gen.sv
module baud_gen #(
  parameter int unsigned BYTE_W   = baud_pkg::BYTE_W,
  parameter int unsigned ZERO_DIV = baud_pkg::ZERO_DIV,
  localparam int unsigned DIV_W   = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [DIV_W-1:0]  divisor_o,
  output logic              tick_o
);
  logic [1:0]       wr_en;
  logic [DIV_W-1:0] div_q, div_d;

  assign wr_en = {wr_hi_i, wr_lo_i};

  baud_div_latch #(
    .BYTE_W    (BYTE_W),
    .NUM_BYTES (2)
  ) i_latch (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en),
    .wdata_i (wdata_i),
    .div_q_o (div_q),
    .div_d_o (div_d)
  );

  baud_div_counter #(
    .DIV_W    (DIV_W),
    .ZERO_DIV (ZERO_DIV)
  ) i_counter (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (|wr_en),
    .div_i  (div_d),
    .tick_o (tick_o)
  );

  assign divisor_o = div_q;
endmodule

// File: rtl/baud_gen_chk.sv
module baud_gen_chk #(
  parameter int unsigned BYTE_W = 8,
  localparam int unsigned DIV_W = 2 * BYTE_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_lo_i,
  input logic              wr_hi_i,
  input logic [BYTE_W-1:0] wdata_i,
  input logic [DIV_W-1:0]  divisor_o,
  input logic              tick_o
);
  logic wr_any;
  assign wr_any = wr_lo_i || wr_hi_i;

  AST_LO_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lo_i |=> divisor_o[BYTE_W-1:0] == $past(wdata_i)); // R2
  AST_LO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_lo_i |=> $stable(divisor_o[BYTE_W-1:0])); // R3
  AST_HI_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_hi_i |=> divisor_o[DIV_W-1:BYTE_W] == $past(wdata_i)); // R3
  AST_HI_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_hi_i |=> $stable(divisor_o[DIV_W-1:BYTE_W])); // R2
  AST_SINGLE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && !wr_any && divisor_o != 16'd1) |=> !tick_o); // R4
  AST_DIV_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_any && divisor_o == 16'd1) |=> tick_o); // R5
  AST_RELOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> (divisor_o == 16'd1 || !tick_o)); // R7
endmodule

bind baud_gen baud_gen_chk #(.BYTE_W(BYTE_W)) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_lo_i   (wr_lo_i),
  .wr_hi_i   (wr_hi_i),
  .wdata_i   (wdata_i),
  .divisor_o (divisor_o),
  .tick_o    (tick_o)
);

// File: tb/test_baud_gen.sv
`timescale 1ns/1ps
module test_baud_gen;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_lo_i = 1'b0;
  logic        wr_hi_i = 1'b0;
  logic [7:0]  wdata_i = 8'h00;
  logic [15:0] divisor_o;
  logic        tick_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  baud_gen i_baud_gen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_lo_i   (wr_lo_i),
    .wr_hi_i   (wr_hi_i),
    .wdata_i   (wdata_i),
    .divisor_o (divisor_o),
    .tick_o    (tick_o)
  );

  // {lo, hi, expected period}
  localparam logic [31:0] VEC [8] = '{
    {8'h00, 8'h00, 16'd3},
    {8'h01, 8'h00, 16'd1},
    {8'h02, 8'h00, 16'd2},
    {8'h05, 8'h00, 16'd5},
    {8'h11, 8'h00, 16'd17},
    {8'h00, 8'h01, 16'd256},
    {8'h2C, 8'h01, 16'd300},
    {8'hFF, 8'h01, 16'd511}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // drive on a falling edge, release on the next; returns at that falling edge
  task automatic wr(input logic lo, input logic hi, input logic [7:0] d);
    @(negedge clk_i);
    wr_lo_i = lo; wr_hi_i = hi; wdata_i = d;
    @(negedge clk_i);
    wr_lo_i = 1'b0; wr_hi_i = 1'b0;
  endtask

  task automatic first_tick(output int k);
    k = 1;
    while (!tick_o && k < 70000) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  task automatic period(output int p);
    p = 0;
    do begin
      @(negedge clk_i);
      p++;
    end while (!tick_o && p < 70000);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k, p;
    string req;
    // R1 reset state and divide-by-3 start
    repeat (3) @(negedge clk_i);
    chk("R1 divisor in reset", divisor_o, 0);
    chk("R1 tick in reset", tick_o, 0);
    rst_ni = 1'b1;
    k = 0;
    while (!tick_o && k < 100) begin
      @(negedge clk_i);
      k++;
    end
    chk("R1 first tick cycle", k, 2);
    period(p);
    chk("R1 period after reset", p, 3);

    // table of divisors: R4/R5/R6 period, R7 reload delay
    for (int i = 0; i < 8; i++) begin
      logic [7:0] lo, hi;
      int n;
      lo = VEC[i][31:24]; hi = VEC[i][23:16]; n = int'(VEC[i][15:0]);
      req = (n == 1) ? "R5" : ((lo == 0 && hi == 0) ? "R6" : "R4");
      wr(1'b1, 1'b0, lo);
      wr(1'b0, 1'b1, hi);
      chk("R2 R3 readback", divisor_o, {hi, lo});
      first_tick(k);
      chk("R7 first tick after write", k, n);
      period(p);
      chk({req, " period"}, p, n);
      @(negedge clk_i);
      chk({req, " tick after pulse"}, tick_o, (n == 1) ? 1 : 0);
    end

    // R7 reload in the middle of a long count
    wr(1'b1, 1'b0, 8'hE8);
    wr(1'b0, 1'b1, 8'h03);
    repeat (100) @(negedge clk_i);
    wr(1'b1, 1'b0, 8'h0A);
    chk("R7 divisor after mid write", divisor_o, 16'h030A);
    first_tick(k);
    chk("R7 mid-count reload", k, 16'h030A);

    // R7 write of zero reloads to divide-by-3
    wr(1'b1, 1'b1, 8'h00);
    first_tick(k);
    chk("R7 zero reload", k, 3);

    // R2 low write leaves high byte alone
    wr(1'b0, 1'b1, 8'h5A);
    wr(1'b1, 1'b0, 8'hC3);
    chk("R2 high byte kept", divisor_o[15:8], 8'h5A);
    chk("R2 low byte written", divisor_o[7:0], 8'hC3);
    // R3 high write leaves low byte alone
    wr(1'b0, 1'b1, 8'h00);
    chk("R3 low byte kept", divisor_o[7:0], 8'hC3);
    chk("R3 high byte written", divisor_o[15:8], 8'h00);
    first_tick(k);
    chk("R3 high write reload", k, 8'hC3);

    // R8 both strobes together
    wr(1'b1, 1'b1, 8'h02);
    chk("R8 both bytes", divisor_o, 16'h0202);
    first_tick(k);
    chk("R8 first tick", k, 16'h0202);

    finish_run();
  end
endmodule